// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs read and write cycles to external data memory over a narrow multiplexed bus. The low address byte and the data byte take turns on one set of shared lines, and the high address byte has its own output lines. A strobe marks the moment the shared lines carry a valid low address, so an external latch can capture it. Separate active-low read and write strobes then time the data transfer. The tri-state pads stay outside the block. It exposes a drive value, a strong output enable and a weak keeper flag for the shared lines, and it takes the pad value back in as an input.

A requester offers an address, a direction flag and write data with a valid/ready handshake. Requests that arrive while a cycle is running are held off. Each cycle ends with a one-cycle done pulse, and for reads the returned byte is presented with it.

The address space is split into a lower and an upper sector at a configurable boundary on the upper address bits. Each sector has its own two-bit wait code, so a fast memory and a slow memory can share the same bus. An optional keeper holds the last driven value on the shared lines whenever the block releases them.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, req_ready is 1, bus_ale is 0, bus_rd_n and bus_wr_n are 1, bus_ad_oe is 0 and rsp_done is 0.
- R2: bus_ale is 1 for exactly the first cycle after a request is accepted, and in no other cycle. In that cycle bus_ad_oe is 1, bus_ad_out carries address bits 7:0, and bus_addr_hi carries address bits 15:8. bus_addr_hi then stays unchanged until the next acceptance.
- R3: The strobe stays low for 1, 2, 3 or 3 cycles for wait codes 00, 01, 10 and 11. Code 11 adds one cycle with both strobes high and bus_ad_oe low after the strobe. rsp_done is raised 2 + strobe length + hold cycles after the ALE cycle: 3, 4, 5 or 6 cycles.
- R4: When address bits 15:8 are greater than or equal to cfg_bound, the request uses cfg_wait_hi. Otherwise it uses cfg_wait_lo. The code is taken when the request is accepted.
- R5: A read samples bus_ad_in at the clock edge that ends the last read-strobe cycle. The sampled byte appears on rsp_rdata in the cycle where rsp_done is 1. rsp_done lasts one cycle.
- R6: In the cycle after ALE, a write drives the write data (bus_ad_oe = 1), while a read releases the lines. During a write strobe, bus_ad_oe is 1 with the write data on bus_ad_out. During a read strobe, bus_ad_oe is 0. Only one of bus_rd_n and bus_wr_n is ever low, and only the one that matches the direction.
- R7: req_ready is 0 from the ALE cycle up to the cycle before rsp_done. It is 1 in idle cycles and in the rsp_done cycle. A request held valid while the block is busy is accepted only when req_ready is 1.
- R8: With cfg_keep_en at 1 and bus_ad_oe at 0, bus_ad_hold is 1 and bus_ad_out holds the last value driven with bus_ad_oe at 1. With cfg_keep_en at 0 and bus_ad_oe at 0, bus_ad_hold is 0 and bus_ad_out is 0.
- R9: A request waiting during the rsp_done cycle is accepted at the end of that cycle, and its ALE cycle follows at once. bus_ale is 0 in the rsp_done cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_done |
| cfg_bound | input | 8 | Lowest upper-address byte of the upper sector |
| cfg_wait_lo | input | 2 | Wait code for the lower sector |
| cfg_wait_hi | input | 2 | Wait code for the upper sector |
| cfg_keep_en | input | 1 | Keeper enable for the shared lines |
| bus_ad_out | output | 8 | Value for the shared address/data lines |
| bus_ad_oe | output | 1 | Strong drive enable for the shared lines |
| bus_ad_hold | output | 1 | Keeper (weak hold) active on the shared lines |
| bus_ad_in | input | 8 | Pad value of the shared lines |
| bus_addr_hi | output | 8 | High address byte lines |
| bus_ale | output | 1 | Address latch strobe, high while the low address is valid |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |

## Verification
The hardest case to reach is a request already waiting when the previous cycle ends. Here the done pulse, the ready rising and the next ALE must follow each other with no idle cycle and no ALE in the done cycle. The stimulus gets there by issuing the next request straight after an acceptance, so it stays valid across the whole busy period. It does this while the two sectors carry different wait codes and the addresses alternate between them. The memory model drives a poison value whenever the read strobe is high, so read data sampled one edge late is caught.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_SETUP,
      ST_STROBE,
      ST_HOLD,
      ST_FIN
   } xb_state_t;

   localparam int WAIT_CODE_W = 2;

   // extra strobe cycles beyond the first one for each wait code
   function automatic logic [1:0] strobe_extra(input logic [WAIT_CODE_W-1:0] code);
      case (code)
         2'b00:   strobe_extra = 2'd0;
         2'b01:   strobe_extra = 2'd1;
         default: strobe_extra = 2'd2;
      endcase
   endfunction

   // the slowest code adds a release cycle after the strobe
   function automatic logic has_hold(input logic [WAIT_CODE_W-1:0] code);
      has_hold = (code == 2'b11);
   endfunction

endpackage

// File: rtl/xbus_sector.sv
module xbus_sector
   import xbus_pkg::*;
#(
   parameter int BND_W = 8
) (
   input  logic [BND_W-1:0]       addr_top,
   input  logic [BND_W-1:0]       bound,
   input  logic [WAIT_CODE_W-1:0] wait_lo,
   input  logic [WAIT_CODE_W-1:0] wait_hi,
   output logic [WAIT_CODE_W-1:0] code
);

   logic upper;

   always_comb begin
      upper = (addr_top >= bound);
      code  = upper ? wait_hi : wait_lo;
   end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [WAIT_CODE_W-1:0] code,
   output xb_state_t              st,
   output logic                   last_strobe
);

   logic [1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            ST_IDLE, ST_FIN: st <= start ? ST_ADDR : ST_IDLE;
            ST_ADDR:         st <= ST_SETUP;
            ST_SETUP: begin
               st  <= ST_STROBE;
               cnt <= strobe_extra(code);
            end
            ST_STROBE: begin
               if (cnt == '0) st <= has_hold(code) ? ST_HOLD : ST_FIN;
               else           cnt <= cnt - 2'd1;
            end
            ST_HOLD:  st <= ST_FIN;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   assign last_strobe = (st == ST_STROBE) && (cnt == '0);

endmodule

// File: rtl/xbus_keeper.sv
module xbus_keeper #(
   parameter int DATA_W     = 8,
   parameter bit HAS_KEEPER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drive_en,
   input  logic [DATA_W-1:0] drive_val,
   input  logic              keep_en,
   output logic [DATA_W-1:0] ad_out,
   output logic              hold
);

   generate
      if (HAS_KEEPER) begin : g_keep
         logic [DATA_W-1:0] last_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        last_q <= '0;
            else if (drive_en) last_q <= drive_val;
         end

         always_comb begin
            hold = !drive_en && keep_en;
            if (drive_en)     ad_out = drive_val;
            else if (keep_en) ad_out = last_q;
            else              ad_out = '0;
         end
      end else begin : g_nokeep
         logic unused_keep;
         assign unused_keep = keep_en ^ clk ^ rst_n;
         assign hold   = 1'b0;
         assign ad_out = drive_en ? drive_val : '0;
      end
   endgenerate

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int BND_W      = 8,
   parameter bit HAS_KEEPER = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_we,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     rsp_done,
   output logic [DATA_W-1:0]        rsp_rdata,
   input  logic [BND_W-1:0]         cfg_bound,
   input  logic [1:0]               cfg_wait_lo,
   input  logic [1:0]               cfg_wait_hi,
   input  logic                     cfg_keep_en,
   output logic [DATA_W-1:0]        bus_ad_out,
   output logic                     bus_ad_oe,
   output logic                     bus_ad_hold,
   input  logic [DATA_W-1:0]        bus_ad_in,
   output logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
   output logic                     bus_ale,
   output logic                     bus_rd_n,
   output logic                     bus_wr_n
);

   localparam int HI_W = ADDR_W - DATA_W;

   generate
      if (DATA_W < 1 || HI_W < 1) begin : g_bad_width
         $error("xbus_ctrl: ADDR_W must exceed DATA_W");
      end
      if (BND_W < 1 || BND_W > ADDR_W) begin : g_bad_bound
         $error("xbus_ctrl: BND_W out of range");
      end
   endgenerate

   xb_state_t              st;
   logic                   last_strobe;
   logic                   accept;
   logic [WAIT_CODE_W-1:0] code_new;
   logic [WAIT_CODE_W-1:0] code_q;
   logic [ADDR_W-1:0]      addr_q;
   logic [DATA_W-1:0]      wdata_q;
   logic                   we_q;
   logic [DATA_W-1:0]      rdata_q;
   logic                   drive_en;
   logic [DATA_W-1:0]      drive_val;

   assign req_ready = (st == ST_IDLE) || (st == ST_FIN);
   assign accept    = req_valid && req_ready;

   xbus_sector #(.BND_W(BND_W)) u_sector (
      .addr_top (req_addr[ADDR_W-1 -: BND_W]),
      .bound    (cfg_bound),
      .wait_lo  (cfg_wait_lo),
      .wait_hi  (cfg_wait_hi),
      .code     (code_new)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         we_q    <= 1'b0;
         code_q  <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         we_q    <= req_we;
         code_q  <= code_new;
      end
   end

   xbus_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept),
      .code        (code_q),
      .st          (st),
      .last_strobe (last_strobe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       rdata_q <= '0;
      else if (last_strobe && !we_q)    rdata_q <= bus_ad_in;
   end

   always_comb begin
      drive_en  = (st == ST_ADDR) ||
                  (we_q && ((st == ST_SETUP) || (st == ST_STROBE)));
      drive_val = (st == ST_ADDR) ? addr_q[DATA_W-1:0] : wdata_q;
   end

   xbus_keeper #(.DATA_W(DATA_W), .HAS_KEEPER(HAS_KEEPER)) u_keep (
      .clk       (clk),
      .rst_n     (rst_n),
      .drive_en  (drive_en),
      .drive_val (drive_val),
      .keep_en   (cfg_keep_en),
      .ad_out    (bus_ad_out),
      .hold      (bus_ad_hold)
   );

   assign bus_ad_oe   = drive_en;
   assign bus_addr_hi = addr_q[ADDR_W-1:DATA_W];
   assign bus_ale     = (st == ST_ADDR);
   assign bus_rd_n    = !((st == ST_STROBE) && !we_q);
   assign bus_wr_n    = !((st == ST_STROBE) && we_q);
   assign rsp_done    = (st == ST_FIN);
   assign rsp_rdata   = rdata_q;

endmodule

module xbus_ctrl_chk #(
   parameter int HI_W       = 8,
   parameter bit HAS_KEEPER = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_ready,
   input logic            rsp_done,
   input logic            cfg_keep_en,
   input logic            bus_ad_oe,
   input logic            bus_ad_hold,
   input logic [HI_W-1:0] bus_addr_hi,
   input logic            bus_ale,
   input logic            bus_rd_n,
   input logic            bus_wr_n
);

   assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |=> !bus_ale);

   assert_ale_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |-> (bus_ad_oe && bus_rd_n && bus_wr_n));

   assert_hi_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !bus_ale) |-> $stable(bus_addr_hi));

   assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_rd_n && !bus_wr_n));

   assert_wr_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> bus_ad_oe);

   assert_rd_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> !bus_ad_oe);

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   assert_busy_on_ale_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |-> !req_ready);

   assert_done_no_ale_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (!bus_ale && req_ready));

   generate
      if (HAS_KEEPER) begin : g_keep_chk
         assert_keeper_R8: assert property (@(posedge clk) disable iff (!rst_n)
            bus_ad_hold == (!bus_ad_oe && cfg_keep_en));
      end
   endgenerate

endmodule

bind xbus_ctrl xbus_ctrl_chk #(.HI_W(ADDR_W - DATA_W), .HAS_KEEPER(HAS_KEEPER)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .rsp_done    (rsp_done),
   .cfg_keep_en (cfg_keep_en),
   .bus_ad_oe   (bus_ad_oe),
   .bus_ad_hold (bus_ad_hold),
   .bus_addr_hi (bus_addr_hi),
   .bus_ale     (bus_ale),
   .bus_rd_n    (bus_rd_n),
   .bus_wr_n    (bus_wr_n)
);

// File: tb/sim_xbus_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_we = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_done;
   logic [7:0]  rsp_rdata;
   logic [7:0]  cfg_bound = 8'h80;
   logic [1:0]  cfg_wait_lo = 2'b00;
   logic [1:0]  cfg_wait_hi = 2'b11;
   logic        cfg_keep_en = 1'b1;
   logic [7:0]  bus_ad_out;
   logic        bus_ad_oe;
   logic        bus_ad_hold;
   logic [7:0]  bus_ad_in;
   logic [7:0]  bus_addr_hi;
   logic        bus_ale;
   logic        bus_rd_n;
   logic        bus_wr_n;

   xbus_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .cfg_bound(cfg_bound),
      .cfg_wait_lo(cfg_wait_lo), .cfg_wait_hi(cfg_wait_hi), .cfg_keep_en(cfg_keep_en),
      .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_hold(bus_ad_hold),
      .bus_ad_in(bus_ad_in), .bus_addr_hi(bus_addr_hi), .bus_ale(bus_ale),
      .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   typedef struct {
      bit        we;
      bit [15:0] addr;
      bit [7:0]  data;
      int        slen;
      int        hold;
   } txn_t;

   txn_t exq[$];
   logic [7:0] ref_mem [int];
   logic [7:0] bus_mem [int];

   function automatic logic [7:0] dflt(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   // external memory model with an address latch
   logic [15:0] lat = '0;
   logic [7:0]  rd_val = '0;
   always @(posedge clk) begin
      if (bus_ale && bus_ad_oe) begin
         lat = {bus_addr_hi, bus_ad_out};
         rd_val = bus_mem.exists(int'(lat)) ? bus_mem[int'(lat)] : dflt(lat);
      end
      if (!bus_wr_n && bus_ad_oe) bus_mem[int'(lat)] = bus_ad_out;
   end
   assign bus_ad_in = bus_rd_n ? 8'hEE : rd_val;

   // driver: offers a request and records the expected result on acceptance
   task automatic do_req(input bit we, input logic [15:0] a, input logic [7:0] d);
      txn_t t;
      logic [1:0] code;
      @(negedge clk); #1;
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      code = (a[15:8] >= cfg_bound) ? cfg_wait_hi : cfg_wait_lo;   // R4
      t.we = we; t.addr = a;
      t.slen = (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 3;
      t.hold = (code == 2'b11) ? 1 : 0;
      if (we) begin
         ref_mem[int'(a)] = d;
         t.data = d;
      end else begin
         t.data = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : dflt(a);
      end
      exq.push_back(t);
   endtask

   task automatic idle(input int n);
      @(negedge clk); #1;
      req_valid = 1'b0;
      repeat (n) @(negedge clk);
      #1;
   endtask

   // monitor / scoreboard
   bit   mon_en = 0;
   bit   act = 0;
   int   k = 0;
   int   slow = 0;
   bit   prev_done = 0;
   bit   pend_b2b = 0;
   logic [7:0] last_drv = '0;
   txn_t cur;

   always @(negedge clk) begin
      if (mon_en && rst_n) begin
         if (pend_b2b) begin
            chk(bus_ale, "R9 ALE right after done with waiting request", bus_ale, 1);
            pend_b2b = 0;
         end
         if (prev_done) chk(!rsp_done, "R5 done lasts one cycle", rsp_done, 0);
         prev_done = rsp_done;

         if (bus_ad_oe) last_drv = bus_ad_out;
         else if (cfg_keep_en)
            chk(bus_ad_hold && bus_ad_out == last_drv, "R8 keeper holds last value",
                {bus_ad_hold, bus_ad_out}, {1'b1, last_drv});
         else
            chk(!bus_ad_hold && bus_ad_out == 8'h00, "R8 keeper off releases",
                {bus_ad_hold, bus_ad_out}, 9'h000);

         if (bus_ale) begin
            chk(!act, "R2 ALE during a running cycle", act, 0);
            if (exq.size() == 0) begin
               chk(1'b0, "R2 ALE with no accepted request", 1, 0);
            end else begin
               cur = exq[0];
               chk(bus_ad_oe && bus_ad_out == cur.addr[7:0] && bus_addr_hi == cur.addr[15:8],
                   "R2 address phase", {bus_ad_oe, bus_addr_hi, bus_ad_out}, {1'b1, cur.addr});
               chk(!req_ready, "R7 busy in ALE cycle", req_ready, 0);
               act = 1; k = 0; slow = 0;
            end
         end else if (act) begin
            k++;
            if (k == 1) begin
               chk(bus_rd_n && bus_wr_n, "R6 no strobe in setup", {bus_rd_n, bus_wr_n}, 2'b11);
               chk(bus_ad_oe == cur.we && (!cur.we || bus_ad_out == cur.data),
                   "R6 setup drive", {bus_ad_oe, bus_ad_out}, {cur.we, cur.we ? cur.data : bus_ad_out});
            end
            if (!bus_rd_n || !bus_wr_n) begin
               slow++;
               if (cur.we)
                  chk(!bus_wr_n && bus_rd_n && bus_ad_oe && bus_ad_out == cur.data,
                      "R6 write strobe drive", {bus_rd_n, bus_wr_n, bus_ad_oe, bus_ad_out},
                      {3'b101, cur.data});
               else
                  chk(!bus_rd_n && bus_wr_n && !bus_ad_oe, "R6 read strobe release",
                      {bus_rd_n, bus_wr_n, bus_ad_oe}, 3'b010);
            end
            if (cur.hold == 1 && k == 2 + cur.slen && !rsp_done)
               chk(bus_rd_n && bus_wr_n && !bus_ad_oe, "R3 hold cycle after strobe",
                   {bus_rd_n, bus_wr_n, bus_ad_oe}, 3'b110);
            if (rsp_done) begin
               chk(k == 2 + cur.slen + cur.hold, "R3 done latency", k, 2 + cur.slen + cur.hold);
               chk(slow == cur.slen, "R4 strobe length for sector code", slow, cur.slen);
               chk(req_ready, "R7 ready in done cycle", req_ready, 1);
               if (!cur.we) chk(rsp_rdata == cur.data, "R5 read data", rsp_rdata, cur.data);
               void'(exq.pop_front());
               act = 0;
               pend_b2b = req_valid;
            end else begin
               chk(!req_ready, "R7 busy mid-cycle", req_ready, 0);
            end
         end else if (rsp_done) begin
            chk(1'b0, "R5 done with no cycle", 1, 0);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(req_ready && !bus_ale && bus_rd_n && bus_wr_n && !bus_ad_oe && !rsp_done,
          "R1 state in reset", {req_ready, bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, rsp_done}, 6'b101100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !bus_ale && bus_rd_n && bus_wr_n && !bus_ad_oe && !rsp_done,
          "R1 state after reset", {req_ready, bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, rsp_done}, 6'b101100);
      mon_en = 1;

      // lower sector no wait, upper sector slowest, keeper on
      do_req(1, 16'h1234, 8'hA5); idle(10);
      do_req(0, 16'h1234, 8'h00); idle(10);
      do_req(1, 16'h9A55, 8'h3C); idle(10);
      do_req(0, 16'h9A55, 8'h00); idle(10);
      do_req(0, 16'h8000, 8'h00); idle(10);   // R4 boundary: upper
      do_req(0, 16'h7FFF, 8'h00); idle(10);   // R4 just below: lower

      // keeper off, one and two wait states
      cfg_wait_lo = 2'b01; cfg_wait_hi = 2'b10; cfg_keep_en = 1'b0;
      do_req(1, 16'h7F01, 8'h81); idle(10);
      do_req(0, 16'h7F01, 8'h00); idle(10);
      do_req(1, 16'h8001, 8'h42); idle(10);
      do_req(0, 16'h8001, 8'h00); idle(10);

      // R9 back-to-back across sectors, keeper on
      cfg_wait_lo = 2'b10; cfg_wait_hi = 2'b00; cfg_keep_en = 1'b1;
      do_req(1, 16'h0010, 8'h11);
      do_req(1, 16'h9010, 8'h22);
      do_req(0, 16'h0010, 8'h00);
      do_req(0, 16'h9010, 8'h00);
      idle(12);

      // boundary extremes
      cfg_bound = 8'h00; cfg_wait_hi = 2'b11; cfg_wait_lo = 2'b00;
      do_req(0, 16'h0000, 8'h00); idle(10);
      cfg_bound = 8'hFF; cfg_wait_hi = 2'b01; cfg_wait_lo = 2'b11;
      do_req(0, 16'hFFFF, 8'h00); idle(10);
      do_req(1, 16'hFEFE, 8'h77);
      do_req(0, 16'hFEFE, 8'h00); idle(12);

      chk(exq.size() == 0, "R5 every request completed", exq.size(), 0);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule